// File: doc/BRIEF.md
# Masked-Compare Periodic Interrupt Timer

This block is a 48-bit up-counter whose value is compared each cycle with a programmable compare word. A per-bit mask removes chosen bit positions from that comparison. When every bit that is still compared agrees, the block sets a sticky interrupt flag. Because low-order bits can be compared while high-order bits are ignored, the match can recur at regular intervals, and it can hit patterns that a plain equality compare cannot reach.

Software drives the block through a simple register port: one write strobe, an address, a write word and a combinational read word, all as wide as the counter. It writes the compare, mask and control fields, reads or loads the counter, and clears the flag by writing 1 to it. The control field can halt the counter, can make the counter restart from zero on a match, and can gate the interrupt output. The live counter value is also driven on a separate timestamp output.

The block runs on a single clock and has a synchronous active-low reset.

Top module: `mct_timer`

## Requirements
- R1: After reset, the counter reads 0, the compare word reads all ones, the mask reads 0, the control field reads 0 and the flag reads 0. The addresses are 0 for compare, 1 for mask, 2 for control, 3 for status and 4 for the counter. Unused addresses read 0.
- R2: While control bit 0 (run) is 1, the counter adds one on every clock. It wraps from all ones to zero, and the wrap sets no flag unless zero is itself a match.
- R3: A mask bit of 1 removes that bit position from the compare. A match needs every bit with a mask bit of 0 to be equal in the counter and the compare word.
- R4: A match sets the flag, and the flag reads as 1 in status bit 0 from the next cycle.
- R5: Writing status with bit 0 set clears the flag. Writing status with bit 0 clear leaves the flag unchanged. A match in the same cycle as a clear leaves the flag set.
- R6: The irq output is high exactly when the flag is set and control bit 2 (interrupt enable) is 1.
- R7: When control bit 1 (restart) is 1 and a match occurs while the counter runs, the next counter value is 0. With restart clear, counting continues past the match.
- R8: While run is 0, the counter holds its value.
- R9: A write to the counter address loads the written value in the next cycle. This load takes priority over counting and restart.
- R10: A match is detected once per counter value. If a halted counter sits on a matching value, the flag does not set again after it is cleared. A new load re-arms detection.
- R11: The timestamp output always equals the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 48 | Register write word |
| reg_rdata | output | 48 | Combinational read word for reg_addr |
| irq | output | 1 | Interrupt request (flag AND enable) |
| timestamp | output | 48 | Live counter value |

## Verification
The bench uses a low-nibble compare with the upper 44 bits masked, so the match fires at 3 and again at 19. A design that compared masked bits would miss the second match. A restart run checks that the counter never passes the compare value, which catches a restart that is ignored or that lands one value late. The wrap from all ones checks that a wrap alone does not set the flag. The halted-on-match case checks that a cleared flag stays clear until a reload. A design that matched every cycle without a once-per-value guard would set the flag again at once.

// File: rtl/mct_pkg.sv
// Package: shared register addresses and control-field layout for the
// masked-compare timer. Assumes a 3-bit register address.
package mct_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CMP  = 3'd0,
        A_MASK = 3'd1,
        A_CTRL = 3'd2,
        A_STAT = 3'd3,
        A_CNT  = 3'd4
    } mct_addr_e;

    // Packed MSB first: irq_en is bit 2, restart bit 1, run bit 0.
    typedef struct packed {
        logic irq_en;
        logic restart;
        logic run;
    } mct_ctrl_t;

    localparam int CTRL_W = $bits(mct_ctrl_t);
endpackage

// File: rtl/mct_match.sv
// Module: mct_match
// Per-bit masked equality between the counter and the compare word.
// Assumes the mask bit 1 means "ignore". The result is qualified by the
// armed input so each counter value can match only once.
module mct_match #(
    parameter int W = 48
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] mask,
    input  logic         armed,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    // One agreement term per bit position; masked bits always agree.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | (cnt[i] ~^ cmp[i]);
    end

    // Reduce all per-bit terms and qualify with the armed state.
    assign hit = armed & (&bit_ok);
endmodule

// File: rtl/mct_counter.sv
// Module: mct_counter
// Free-running up-counter with load, halt and restart-on-match, plus the
// "armed" bit that allows one match per counter value. Assumes the load
// request has priority over counting.
module mct_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         restart,
    input  logic         hit,
    output logic [W-1:0] cnt,
    output logic         armed
);
    localparam logic [W-1:0] ONE = W'(1);

    // Counter value: load, else step or restart when running, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run) begin
            if (restart && hit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    // Armed bit: set whenever the value is refreshed, dropped after a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (load || run) begin
            armed <= 1'b1;
        end else if (hit) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/mct_regs.sv
// Module: mct_regs
// Compare, mask and control registers, the sticky interrupt flag and
// the combinational read mux. Assumes set-on-match beats write-1-clear.
module mct_regs
    import mct_pkg::*;
#(
    parameter int W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      cnt,
    input  logic              hit,
    output logic [W-1:0]      cmp,
    output logic [W-1:0]      mask,
    output mct_ctrl_t         ctrl,
    output logic              flag,
    output logic [W-1:0]      rdata
);
    logic clr_req;

    // Decode a write-1-to-clear on the status address.
    assign clr_req = we && (addr == A_STAT) && wdata[0];

    // Configuration registers written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp  <= '1;
            mask <= '0;
            ctrl <= '0;
        end else if (we) begin
            case (addr)
                A_CMP:   cmp  <= wdata;
                A_MASK:  mask <= wdata;
                A_CTRL:  ctrl <= mct_ctrl_t'(wdata[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    // Sticky flag: set by a match, cleared by software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // Read mux; unused addresses return zero.
    always_comb begin
        case (addr)
            A_CMP:   rdata = cmp;
            A_MASK:  rdata = mask;
            A_CTRL:  rdata = {{(W-CTRL_W){1'b0}}, ctrl};
            A_STAT:  rdata = {{(W-1){1'b0}}, flag};
            A_CNT:   rdata = cnt;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/mct_timer.sv
// Module: mct_timer (top)
// Masked-compare periodic interrupt timer: register file, counter and
// masked comparator. Assumes one clock and a synchronous active-low reset.
module mct_timer
    import mct_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic [CNT_W-1:0]  timestamp
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] mask_q;
    mct_ctrl_t        ctrl_q;
    logic             flag_q;
    logic             armed_q;
    logic             hit;
    logic             cnt_load;

    // A write to the counter address is a direct load.
    assign cnt_load = reg_we && (reg_addr == A_CNT);

    mct_regs #(.W(CNT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cnt   (cnt_q),
        .hit   (hit),
        .cmp   (cmp_q),
        .mask  (mask_q),
        .ctrl  (ctrl_q),
        .flag  (flag_q),
        .rdata (reg_rdata)
    );

    mct_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (reg_wdata),
        .run      (ctrl_q.run),
        .restart  (ctrl_q.restart),
        .hit      (hit),
        .cnt      (cnt_q),
        .armed    (armed_q)
    );

    mct_match #(.W(CNT_W)) u_match (
        .cnt   (cnt_q),
        .cmp   (cmp_q),
        .mask  (mask_q),
        .armed (armed_q),
        .hit   (hit)
    );

    // Gate the flag with the enable; export the live count.
    assign irq       = flag_q & ctrl_q.irq_en;
    assign timestamp = cnt_q;
endmodule

// File: rtl/mct_timer_chk.sv
// Module: mct_timer_chk
// Property checker for mct_timer, attached to every instance by bind.
module mct_timer_chk #(
    parameter int W = 48
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_we,
    input logic [2:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp,
    input logic [W-1:0] mask,
    input logic         hit,
    input logic         flag,
    input logic         run,
    input logic         restart,
    input logic         irq
);
    logic load;
    logic clr;
    assign load = reg_we && (reg_addr == 3'd4);
    assign clr  = reg_we && (reg_addr == 3'd3) && reg_wdata[0];

    p_hit_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (((cnt ^ cmp) & ~mask) == '0));

    p_flag_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !(hit && restart)) |=> (cnt == $past(cnt) + W'(1)));

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && hit && restart) |=> (cnt == '0));

    p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));

    p_load_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(reg_wdata)));

    p_single_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !run && !load) |=> !hit);
endmodule

bind mct_timer mct_timer_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt       (cnt_q),
    .cmp       (cmp_q),
    .mask      (mask_q),
    .hit       (hit),
    .flag      (flag_q),
    .run       (ctrl_q.run),
    .restart   (ctrl_q.restart),
    .irq       (irq)
);

// File: tb/mct_timer_tb_top.sv
// Bench for mct_timer: behavioural reference model compared on every
// clock, plus directed checks per requirement.
module mct_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         irq;
    logic [W-1:0] timestamp;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mct_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .timestamp (timestamp)
    );

    // Reference model state
    logic [W-1:0] m_cnt, m_cmp, m_mask;
    logic [2:0]   m_ctrl;
    bit           m_flag, m_armed;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '1; m_mask = '0; m_ctrl = 3'd0;
            m_flag = 1'b0; m_armed = 1'b1;
        end else begin
            automatic bit h = m_armed && (((m_cnt ^ m_cmp) & ~m_mask) == '0);
            automatic bit ld = reg_we && reg_addr == 3'd4;
            automatic bit cl = reg_we && reg_addr == 3'd3 && reg_wdata[0];
            if (ld) m_cnt = reg_wdata;
            else if (m_ctrl[0]) m_cnt = (h && m_ctrl[1]) ? '0 : m_cnt + 1;
            if (ld || m_ctrl[0]) m_armed = 1'b1;
            else if (h) m_armed = 1'b0;
            if (h) m_flag = 1'b1;
            else if (cl) m_flag = 1'b0;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_cmp = reg_wdata;
                    3'd1: m_mask = reg_wdata;
                    3'd2: m_ctrl = reg_wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [W-1:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cmp;
            3'd1: return m_mask;
            3'd2: return {{(W-3){1'b0}}, m_ctrl};
            3'd3: return {{(W-1){1'b0}}, m_flag};
            3'd4: return m_cnt;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 readback", reg_rdata, m_read(reg_addr));
            check("R6 irq", W'(irq), W'(m_flag && m_ctrl[2]));
            check("R11 timestamp", timestamp, m_cnt);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [W-1:0] v, v2;
        logic [W-1:0] mx;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check("R1 compare", v, '1);
        rd(3'd1, v); check("R1 mask", v, '0);
        rd(3'd2, v); check("R1 ctrl", v, '0);
        rd(3'd3, v); check("R1 status", v, '0);
        rd(3'd4, v); check("R1 count", v, '0);
        rd(3'd6, v); check("R1 unused", v, '0);

        // R4/R6/R5: plain compare with irq enabled
        wr(3'd0, W'(20));
        wr(3'd2, W'(5));
        repeat (30) @(posedge clk);
        rd(3'd3, v); check("R4 flag after match", v, W'(1));
        check("R6 irq high", W'(irq), W'(1));
        wr(3'd3, W'(0));
        rd(3'd3, v); check("R5 write 0 keeps flag", v, W'(1));
        wr(3'd3, W'(1));
        rd(3'd3, v); check("R5 write 1 clears", v, W'(0));

        // R3: only low nibble compared
        wr(3'd2, W'(0));
        wr(3'd0, W'(3));
        wr(3'd1, ~W'(15));
        wr(3'd4, W'(0));
        wr(3'd2, W'(1));
        repeat (5) @(posedge clk);
        rd(3'd3, v); check("R3 nibble match at 3", v, W'(1));
        check("R6 irq gated off", W'(irq), W'(0));
        wr(3'd3, W'(1));
        repeat (14) @(posedge clk);
        rd(3'd3, v); check("R3 high bits ignored", v, W'(1));

        // R7: restart on match
        wr(3'd2, W'(0));
        wr(3'd1, W'(0));
        wr(3'd0, W'(5));
        wr(3'd3, W'(1));
        wr(3'd4, W'(0));
        wr(3'd2, W'(3));
        mx = '0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (timestamp > mx) mx = timestamp;
        end
        check("R7 never passes compare", mx, W'(5));

        // R2: wrap from all ones without a flag
        wr(3'd2, W'(0));
        wr(3'd0, W'(256));
        wr(3'd3, W'(1));
        wr(3'd4, '1 - W'(2));
        wr(3'd2, W'(1));
        repeat (6) @(posedge clk);
        rd(3'd3, v); check("R2 wrap sets no flag", v, W'(0));
        check("R2 wrapped small", W'(timestamp < W'(16)), W'(1));

        // R8: halt holds value
        wr(3'd2, W'(0));
        rd(3'd4, v);
        repeat (5) @(posedge clk);
        rd(3'd4, v2); check("R8 halted count", v2, v);
        check("R11 timestamp matches count", timestamp, v2);

        // R9/R10: load onto matching value while halted
        wr(3'd4, W'(256));
        rd(3'd4, v); check("R9 load value", v, W'(256));
        rd(3'd3, v); check("R10 load then match", v, W'(1));
        wr(3'd3, W'(1));
        repeat (4) @(posedge clk);
        rd(3'd3, v); check("R10 no retrigger", v, W'(0));
        wr(3'd4, W'(256));
        rd(3'd3, v); check("R10 reload rearms", v, W'(1));

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule